// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Generator

This block drives the control pins of an 8-bit asynchronous external memory, such as a NAND flash device, from a simple host request port. Each accepted request becomes one bus access. The access runs a setup phase, a strobe phase and a hold phase, and each phase length is counted in controller clock cycles. A turnaround gap follows before the next request can be taken. The phase lengths come from one packed 32-bit timing word. Reads and writes each have their own setup, strobe and hold fields, and a single turnaround field is shared by both.

The host presents the address, the write data, a read/write select and two latch flags. One flag marks a command cycle and the other marks an address cycle. The block asserts the matching latch line to the memory for the whole access. On a read, the byte on the data input is captured in the final cycle of the read strobe and returned with a one-cycle completion pulse. The memory's ready/busy line is brought into the clock domain and presented as a status bit.

Top module: `amem_strobe_gen`

## Requirements
- R1: While reset is held, and after it is released, the chip select and both strobes are high, both latch lines are low, the output enable is low, `req_ack` is high and `rsp_valid` is low.
- R2: The timing word is decoded at fixed positions:
  - write setup is bits 29:26, write strobe is 25:20 and write hold is 19:17;
  - read setup is 16:13, read strobe is 12:7 and read hold is 6:4;
  - turnaround is bits 3:2.
  A read uses only the read fields, and a write uses only the write fields. Bits 31:30 and the bus-size field 1:0 (where 0 selects the 8-bit bus) have no effect on timing.
- R3: A write holds `mem_cs_n` low for (setup+1)+(strobe+1)+(hold+1) cycles. `mem_we_n` is low for exactly strobe+1 consecutive cycles, starting after setup+1 cycles of chip select. Throughout the access, `mem_re_n` stays high, `mem_doe` is high and `mem_dout` carries the write data.
- R4: A read holds `mem_cs_n` low for (setup+1)+(strobe+1)+(hold+1) cycles. `mem_re_n` is low for exactly strobe+1 consecutive cycles, starting after setup+1 cycles. During the read, `mem_we_n` stays high and `mem_doe` stays low.
- R5: `rsp_rdata` takes the value of `mem_din` sampled in the last cycle of the read strobe. It keeps that value when `mem_din` changes later.
- R6: For the whole time `mem_cs_n` is low, `mem_cle` equals the command flag and `mem_ale` equals the address flag latched with the request. Both latch lines are low at all other times. `mem_addr` carries the request address during the access.
- R7: `req_ack` is high only when no access or turnaround is in progress. A request is taken in a cycle where `req_valid` and `req_ack` are both high. After chip select rises, turnaround+1 cycles pass before `req_ack` returns high.
- R8: `rsp_valid` is a one-cycle pulse in the first cycle after chip select rises.
- R9: The timing word is sampled when a request is accepted. Changing it during an access does not alter that access.
- R10: `dev_ready` follows `mem_rdy` after SYNC_STAGES (default 2) clock edges.
- R11: The two strobes are never low together, and a strobe is low only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 32 | Packed phase timing word |
| req_valid | input | 1 | Host request present |
| req_ack | output | 1 | Block idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cmd_latch | input | 1 | Access is a command cycle |
| req_addr_latch | input | 1 | Access is an address cycle |
| req_addr | input | ADDR_W | Memory address |
| req_wdata | input | DATA_W | Write data byte |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | DATA_W | Last captured read byte |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cle | output | 1 | Command latch line |
| mem_ale | output | 1 | Address latch line |
| mem_addr | output | ADDR_W | Address pins |
| mem_dout | output | DATA_W | Data out to memory |
| mem_doe | output | 1 | Data output enable |
| mem_din | input | DATA_W | Data in from memory |
| mem_rdy | input | 1 | Memory ready/busy line |
| dev_ready | output | 1 | Synchronised ready status |

## Verification
The bound checker watches the pin relations on every cycle:
- strobes are mutually exclusive and fall only inside chip select;
- latch lines appear only inside chip select;
- accepting a request leads straight into a setup cycle;
- the completion pulse lasts one cycle and comes right after chip select rises;
- the output enable tracks the write strobe.

The exact phase lengths for each field value can only be shown by the bench's sweeps, because they depend on the programmed word. The same holds for which direction's fields a read or write uses, for the read byte captured on the last strobe cycle, for the immunity to changes of the word in mid-access, and for the synchroniser latency.

// File: rtl/amem_pkg.sv
package amem_pkg;

    // Shared down-counter width, wide enough for the largest field (6 bits)
    localparam int CNT_W = 6;

    // Timing word field positions, as software programs them
    localparam int WR_SETUP_LSB  = 26;
    localparam int WR_SETUP_W    = 4;
    localparam int WR_STROBE_LSB = 20;
    localparam int WR_STROBE_W   = 6;
    localparam int WR_HOLD_LSB   = 17;
    localparam int WR_HOLD_W     = 3;
    localparam int RD_SETUP_LSB  = 13;
    localparam int RD_SETUP_W    = 4;
    localparam int RD_STROBE_LSB = 7;
    localparam int RD_STROBE_W   = 6;
    localparam int RD_HOLD_LSB   = 4;
    localparam int RD_HOLD_W     = 3;
    localparam int TURN_LSB      = 2;
    localparam int TURN_W        = 2;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
    } dir_timing_t;

    typedef struct packed {
        dir_timing_t      wr;
        dir_timing_t      rd;
        logic [CNT_W-1:0] turn;
    } timing_t;

endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
    import amem_pkg::*;
(
    input  logic [31:0] cfg_i,
    output timing_t     tim_o
);

    // Reserved top bits and the bus-size field play no part in timing
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_i[31:30], cfg_i[1:0]};

    always_comb begin
        tim_o.wr.setup  = CNT_W'(cfg_i[WR_SETUP_LSB  +: WR_SETUP_W]);
        tim_o.wr.strobe = CNT_W'(cfg_i[WR_STROBE_LSB +: WR_STROBE_W]);
        tim_o.wr.hold   = CNT_W'(cfg_i[WR_HOLD_LSB   +: WR_HOLD_W]);
        tim_o.rd.setup  = CNT_W'(cfg_i[RD_SETUP_LSB  +: RD_SETUP_W]);
        tim_o.rd.strobe = CNT_W'(cfg_i[RD_STROBE_LSB +: RD_STROBE_W]);
        tim_o.rd.hold   = CNT_W'(cfg_i[RD_HOLD_LSB   +: RD_HOLD_W]);
        tim_o.turn      = CNT_W'(cfg_i[TURN_LSB      +: TURN_W]);
    end

endmodule

// File: rtl/amem_phase_seq.sv
module amem_phase_seq
    import amem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    wr_i,
    input  timing_t tim_i,
    output phase_e  phase_o,
    output logic    last_o,
    output logic    wr_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        dir_timing_t      dir;
        logic [CNT_W-1:0] turn;
        logic             wr;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, default: '0};

    seq_t seq_d, seq_q;
    logic cnt_zero;

    assign cnt_zero = (seq_q.cnt == '0);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.wr    = wr_i;
                    seq_d.dir   = wr_i ? tim_i.wr : tim_i.rd;
                    seq_d.turn  = tim_i.turn;
                    seq_d.cnt   = wr_i ? tim_i.wr.setup : tim_i.rd.setup;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    seq_d.phase = PH_STROBE;
                    seq_d.cnt   = seq_q.dir.strobe;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt_zero) begin
                    seq_d.phase = PH_HOLD;
                    seq_d.cnt   = seq_q.dir.hold;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    seq_d.phase = PH_TURN;
                    seq_d.cnt   = seq_q.turn;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_TURN: begin
                if (cnt_zero) begin
                    seq_d.phase = PH_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign last_o  = cnt_zero;
    assign wr_o    = seq_q.wr;

endmodule

// File: rtl/amem_ready_sync.sv
module amem_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_i,
    output logic rdy_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = (sync_q << 1) | STAGES'(rdy_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rdy_o = sync_q[STAGES-1];

endmodule

// File: rtl/amem_strobe_gen.sv
module amem_strobe_gen
    import amem_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic              req_write,
    input  logic              req_cmd_latch,
    input  logic              req_addr_latch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_re_n,
    output logic              mem_we_n,
    output logic              mem_cle,
    output logic              mem_ale,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_rdy,
    output logic              dev_ready
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cle;
        logic              ale;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } acc_t;

    timing_t tim;
    phase_e  phase;
    logic    last;
    logic    acc_wr;
    logic    accept;
    logic    in_access;
    acc_t    acc_d, acc_q;

    amem_cfg_decode u_decode (
        .cfg_i (cfg_word),
        .tim_o (tim)
    );

    assign accept = req_valid && (phase == PH_IDLE);

    amem_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .wr_i    (req_write),
        .tim_i   (tim),
        .phase_o (phase),
        .last_o  (last),
        .wr_o    (acc_wr)
    );

    amem_ready_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy_i (mem_rdy),
        .rdy_o (dev_ready)
    );

    // Next-state for the access record, read capture and completion pulse
    always_comb begin
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        if (accept) begin
            acc_d.addr  = req_addr;
            acc_d.wdata = req_wdata;
            acc_d.cle   = req_cmd_latch;
            acc_d.ale   = req_addr_latch;
        end
        if ((phase == PH_STROBE) && last && !acc_wr) begin
            acc_d.rdata = mem_din;
        end
        if ((phase == PH_HOLD) && last) begin
            acc_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Pin decode straight from registered phase state
    assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign req_ack   = (phase == PH_IDLE);
    assign mem_cs_n  = !in_access;
    assign mem_re_n  = !((phase == PH_STROBE) && !acc_wr);
    assign mem_we_n  = !((phase == PH_STROBE) && acc_wr);
    assign mem_cle   = in_access && acc_q.cle;
    assign mem_ale   = in_access && acc_q.ale;
    assign mem_addr  = in_access ? acc_q.addr : '0;
    assign mem_doe   = in_access && acc_wr;
    assign mem_dout  = (in_access && acc_wr) ? acc_q.wdata : '0;
    assign rsp_valid = acc_q.done;
    assign rsp_rdata = acc_q.rdata;

endmodule

// File: rtl/amem_strobe_gen_chk.sv
module amem_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ack,
    input logic rsp_valid,
    input logic mem_cs_n,
    input logic mem_re_n,
    input logic mem_we_n,
    input logic mem_cle,
    input logic mem_ale,
    input logic mem_doe
);

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_re_n && !mem_we_n));

    // R11
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re_n || !mem_we_n) |-> !mem_cs_n);

    // R6
    latch_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cle || mem_ale) |-> !mem_cs_n);

    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> mem_cs_n);

    // R7
    accept_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (!mem_cs_n && mem_re_n && mem_we_n));

    // R8
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    rsp_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (mem_cs_n && $past(!mem_cs_n)));

    // R3
    we_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R4
    re_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_re_n) |-> $past(!mem_cs_n));

    // R3
    oe_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_doe);

    // R4
    no_oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re_n |-> !mem_doe);

endmodule

bind amem_strobe_gen amem_strobe_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_re_n  (mem_re_n),
    .mem_we_n  (mem_we_n),
    .mem_cle   (mem_cle),
    .mem_ale   (mem_ale),
    .mem_doe   (mem_doe)
);

// File: tb/amem_strobe_gen_test.sv
`timescale 1ns/1ps
module amem_strobe_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic        req_ack;
    logic        req_write = 1'b0;
    logic        req_cmd_latch = 1'b0;
    logic        req_addr_latch = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_cs_n, mem_re_n, mem_we_n, mem_cle, mem_ale, mem_doe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = '0;
    logic        mem_rdy = 1'b0;
    logic        dev_ready;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    amem_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_ack(req_ack), .req_write(req_write),
        .req_cmd_latch(req_cmd_latch), .req_addr_latch(req_addr_latch),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
        .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
        .mem_rdy(mem_rdy), .dev_ready(dev_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input int ws, input int wst, input int wh,
                                          input int rs, input int rst, input int rh,
                                          input int ta, input logic [31:0] junk);
        logic [31:0] c;
        c = junk & 32'hC000_0003;
        c[29:26] = 4'(ws);
        c[25:20] = 6'(wst);
        c[19:17] = 3'(wh);
        c[16:13] = 4'(rs);
        c[12:7]  = 6'(rst);
        c[6:4]   = 3'(rh);
        c[3:2]   = 2'(ta);
        return c;
    endfunction

    task automatic run_access(input logic [31:0] cfg, input bit wr, input bit cle,
                              input bit ale, input bit scramble,
                              input logic [15:0] addr, input logic [7:0] wdata,
                              input logic [7:0] dbase);
        int su, st, hd, ta;
        int cs_len, sfirst, slen, other, flag_bad, oe_bad, bus_bad, tlen, idle_bad;
        logic strobe_pin, other_pin;
        logic [7:0] exp_rd;
        cs_len = 0; sfirst = -1; slen = 0; other = 0; flag_bad = 0;
        oe_bad = 0; bus_bad = 0; tlen = 0; idle_bad = 0;
        su = wr ? int'(cfg[29:26]) + 1 : int'(cfg[16:13]) + 1;
        st = wr ? int'(cfg[25:20]) + 1 : int'(cfg[12:7]) + 1;
        hd = wr ? int'(cfg[19:17]) + 1 : int'(cfg[6:4]) + 1;
        ta = int'(cfg[3:2]) + 1;
        exp_rd = dbase + 8'(st - 1);

        cfg_word = cfg; req_write = wr; req_cmd_latch = cle; req_addr_latch = ale;
        req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
        chk("R7 ack high when idle", int'(req_ack), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) cfg_word = $urandom;
        while (mem_cs_n === 1'b0 && cs_len < 400) begin
            strobe_pin = wr ? mem_we_n : mem_re_n;
            other_pin  = wr ? mem_re_n : mem_we_n;
            if (!strobe_pin) begin
                if (sfirst < 0) sfirst = cs_len;
                if (!wr) mem_din = dbase + 8'(slen);
                slen++;
            end
            if (!other_pin) other++;
            if (mem_cle !== cle || mem_ale !== ale) flag_bad++;
            if (mem_doe !== wr) oe_bad++;
            if (mem_addr !== addr || (wr && mem_dout !== wdata)) bus_bad++;
            cs_len++;
            @(negedge clk);
        end
        if (!wr) mem_din = ~dbase;
        chk("R8 rsp_valid after cs rises", int'(rsp_valid), 1);
        while (req_ack !== 1'b1 && tlen < 100) begin
            if (mem_cs_n !== 1'b1 || mem_cle !== 1'b0 || mem_ale !== 1'b0) idle_bad++;
            tlen++;
            @(negedge clk);
        end
        if (wr) begin
            chk(scramble ? "R9 R3 write cs length" : "R2 R3 write cs length", cs_len, su + st + hd);
            chk("R3 write strobe start", sfirst, su);
            chk("R3 write strobe length", slen, st);
            chk("R3 re_n low during write", other, 0);
            chk("R3 oe during write", oe_bad, 0);
            chk("R3 addr/data during write", bus_bad, 0);
        end else begin
            chk(scramble ? "R9 R4 read cs length" : "R2 R4 read cs length", cs_len, su + st + hd);
            chk("R4 read strobe start", sfirst, su);
            chk("R4 read strobe length", slen, st);
            chk("R4 we_n low during read", other, 0);
            chk("R4 oe during read", oe_bad, 0);
            chk("R6 addr during read", bus_bad, 0);
            chk("R5 read data", int'(rsp_rdata), int'(exp_rd));
        end
        chk("R6 latch lines during access", flag_bad, 0);
        chk("R6 R7 pins idle in turnaround", idle_bad, 0);
        chk("R7 turnaround length", tlen, ta);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog R7 actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 cs_n in reset", int'(mem_cs_n), 1);
        chk("R1 re_n in reset", int'(mem_re_n), 1);
        chk("R1 we_n in reset", int'(mem_we_n), 1);
        chk("R1 latch lines in reset", int'(mem_cle | mem_ale | mem_doe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ack after reset", int'(req_ack), 1);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1 cs/strobes after reset", int'({mem_cs_n, mem_re_n, mem_we_n}), 7);

        // R10 ready synchroniser latency
        chk("R10 dev_ready low", int'(dev_ready), 0);
        mem_rdy = 1'b1;
        @(negedge clk);
        chk("R10 dev_ready after one edge", int'(dev_ready), 0);
        @(negedge clk);
        chk("R10 dev_ready after two edges", int'(dev_ready), 1);
        mem_rdy = 1'b0;
        @(negedge clk);
        chk("R10 busy after one edge", int'(dev_ready), 1);
        @(negedge clk);
        chk("R10 busy after two edges", int'(dev_ready), 0);

        // Example programming, then field maxima
        run_access(mkcfg(1, 3, 1, 1, 5, 1, 3, 32'h0), 1'b1, 1'b1, 1'b0, 1'b0, 16'h0012, 8'h70, 8'h00);
        run_access(mkcfg(1, 3, 1, 1, 5, 1, 3, 32'h0), 1'b0, 1'b0, 1'b1, 1'b0, 16'h0034, 8'h00, 8'h40);
        run_access(mkcfg(15, 63, 7, 15, 63, 7, 3, 32'hFFFF_FFFF), 1'b1, 1'b0, 1'b0, 1'b1, 16'hBEEF, 8'hA5, 8'h00);
        run_access(mkcfg(15, 63, 7, 15, 63, 7, 3, 32'hFFFF_FFFF), 1'b0, 1'b1, 1'b1, 1'b1, 16'hCAFE, 8'h00, 8'h80);
        run_access(mkcfg(0, 0, 0, 0, 0, 0, 0, 32'h0), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 8'h00, 8'h11);

        // Sweep small field values; the unused direction gets different values
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++)
                for (int t = 0; t < 4; t++)
                    for (int h = 0; h < 2; h++)
                        for (int a = 0; a < 4; a++) begin
                            logic [31:0] cfg;
                            if (w == 1)
                                cfg = mkcfg(s, t, h, 2 - s, 3 - t, 1 - h, a, $urandom);
                            else
                                cfg = mkcfg(2 - s, 3 - t, 1 - h, s, t, h, a, $urandom);
                            run_access(cfg, w[0], a[0], t[0], ((s + t + h + a) % 3) == 0,
                                       16'(s * 256 + t * 16 + a), 8'(t * 37 + a),
                                       8'(h * 100 + s * 20 + a));
                        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule